// File: doc/BRIEF.md
# External Interrupt Sense Unit

The block watches three asynchronous interrupt pins and turns their activity into pending request flags for a downstream interrupt controller. Each pin is first brought into the clock domain by a two-flop synchronizer, then judged according to a sense setting for that pin. Pins 0 and 1 each take a two-bit field selecting low-level, any-edge, falling-edge or rising-edge sensing. Pin 2 takes a single bit choosing between falling and rising edge.

Edge requests are held in a flag until the interrupt controller returns a one-cycle clear strobe for that pin. Low-level requests are not stored. A pin set to low level must read low for a qualifying run of consecutive synchronized cycles before its flag rises. The flag then follows the pin and falls again once the pin is released. A per-pin enable gates everything, and a disabled pin never shows a pending flag.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three flags are 0. The synchronizer stages reset to 1, which is the idle level of the pins.
- R2: In edge modes, a pin level first sampled at clock edge k sets the flag after edge k+2.
- R3: For pins 0 and 1, sense field bits [1:0] belong to pin 0 and bits [3:2] to pin 1. The encoding is 00 = low level, 01 = any edge, 10 = falling edge, 11 = rising edge.
- R4: For pin 2, control bit 0 selects falling edge and 1 selects rising edge.
- R5: An edge flag stays set until its own clear strobe is high at a clock edge, and then reads 0 after that edge. A clear strobe for another pin has no effect on it.
- R6: If a qualifying edge is detected in the same cycle as that pin's clear strobe, the flag stays set.
- R7: In low-level mode, the flag rises only after the synchronized pin has been low for LOW_CYCLES (default 5) consecutive cycles. A pin low for 4 sampled cycles never raises it.
- R8: In low-level mode, the flag stays high while the pin stays low and ignores clear strobes. It returns to 0 by the fourth clock edge after the pin is sampled high.
- R9: While a pin's enable is 0, its flag reads 0 from the next clock edge on, and pin activity in that time never raises it.
- R10: An edge of the polarity that is not selected never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Raw interrupt pins, idle high |
| en_i | input | 3 | Per-pin enable |
| sense_full_i | input | 4 | Sense fields for pins 0 and 1 |
| sense_edge_i | input | 1 | Edge polarity bit for pin 2 |
| clr_i | input | 3 | Per-pin flag clear strobe |
| flag_o | output | 3 | Pending request flags |

## Verification
The bench targets four corner cases.

- **Qualification boundary.** It holds a level-mode pin low for four cycles and then for a long run. A counter that is off by one either fires on the short pulse or waits one cycle too long.
- **Clear colliding with an edge.** It lands a clear strobe in the very cycle a new edge is detected. A design that gives the clear priority loses that request.
- **Polarity and neighbours.** It drives the unselected polarity and strobes the neighbouring pins' clears. Swapped mode decoding or crossed clear wiring then shows up as a stray or missing flag.
- **Random traffic.** Long random runs compare every flag against a cycle model, including through mode and enable changes.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eis_edge_det.sv
module eis_edge_det #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign prev_o = prev_q;
  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/eis_low_qual.sv
module eis_low_qual #(
  parameter int unsigned WIDTH      = 2,
  parameter int unsigned LOW_CYCLES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] qual_o
);
  localparam int unsigned CNT_W = $clog2(LOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOW_CYCLES);

  for (genvar g = 0; g < WIDTH; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (lvl_i[g])       cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign qual_o[g] = (cnt_q == CNT_MAX);
  end
endmodule

// File: rtl/eis_full_chan.sv
module eis_full_chan
  import ext_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sense_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       qual_i,
  input  logic       clr_i,
  output logic       flag_o
);
  sense_e mode;
  logic   hit, flag_d, flag_q;

  assign mode = sense_e'(sense_i);

  always_comb begin
    unique case (mode)
      SENSE_ANY:  hit = rise_i | fall_i;
      SENSE_FALL: hit = fall_i;
      SENSE_RISE: hit = rise_i;
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!en_i)                  flag_d = 1'b0;
    else if (mode == SENSE_LOW) flag_d = qual_i;
    else                        flag_d = hit | (flag_q & ~clr_i);  // new edge beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/eis_edge_chan.sv
module eis_edge_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pol_rise_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic clr_i,
  output logic flag_o
);
  logic hit, flag_q;

  assign hit = pol_rise_i ? rise_i : fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (!en_i) flag_q <= 1'b0;
    else            flag_q <= hit | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int unsigned NUM_PINS    = 3,
  parameter int unsigned NUM_FULL    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOW_CYCLES  = 5,
  localparam int unsigned NUM_EDGE   = NUM_PINS - NUM_FULL
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PINS-1:0]   en_i,
  input  logic [2*NUM_FULL-1:0] sense_full_i,
  input  logic [NUM_EDGE-1:0]   sense_edge_i,
  input  logic [NUM_PINS-1:0]   clr_i,
  output logic [NUM_PINS-1:0]   flag_o
);
  logic [NUM_PINS-1:0] pin_s, pin_q, rise, fall;
  logic [NUM_FULL-1:0] qual;

  eis_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  eis_edge_det #(.WIDTH(NUM_PINS)) i_edge (
    .clk_i, .rst_ni, .lvl_i(pin_s), .prev_o(pin_q), .rise_o(rise), .fall_o(fall)
  );

  eis_low_qual #(.WIDTH(NUM_FULL), .LOW_CYCLES(LOW_CYCLES)) i_qual (
    .clk_i, .rst_ni, .lvl_i(pin_s[NUM_FULL-1:0]), .qual_o(qual)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chan
    if (g < NUM_FULL) begin : g_full
      eis_full_chan i_chan (
        .clk_i, .rst_ni,
        .en_i(en_i[g]), .sense_i(sense_full_i[2*g +: 2]),
        .rise_i(rise[g]), .fall_i(fall[g]), .qual_i(qual[g]),
        .clr_i(clr_i[g]), .flag_o(flag_o[g])
      );
    end else begin : g_edge
      eis_edge_chan i_chan (
        .clk_i, .rst_ni,
        .en_i(en_i[g]), .pol_rise_i(sense_edge_i[g-NUM_FULL]),
        .rise_i(rise[g]), .fall_i(fall[g]),
        .clr_i(clr_i[g]), .flag_o(flag_o[g])
      );
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int unsigned NUM_PINS   = 3,
  parameter int unsigned NUM_FULL   = 2,
  parameter int unsigned LOW_CYCLES = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PINS-1:0]   en_i,
  input logic [2*NUM_FULL-1:0] sense_full_i,
  input logic [NUM_PINS-1:0]   clr_i,
  input logic [NUM_PINS-1:0]   pin_s,
  input logic [NUM_PINS-1:0]   pin_q,
  input logic [NUM_PINS-1:0]   flag_o
);
  localparam int unsigned RUN_W = $clog2(LOW_CYCLES + 1);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic lvl;
    if (g < NUM_FULL) begin : g_m
      assign lvl = (sense_full_i[2*g +: 2] == 2'b00);
    end else begin : g_m
      assign lvl = 1'b0;
    end

    assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |=> !flag_o[g]);

    assert_edge_flag_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g] && !lvl && flag_o[g] && !clr_i[g]) |=> flag_o[g]);

    assert_no_edge_no_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g] && !lvl && !flag_o[g] && pin_s[g] == pin_q[g]) |=> !flag_o[g]);

    if (g < NUM_FULL) begin : g_lvl
      logic [RUN_W-1:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       run_q <= '0;
        else if (pin_s[g])                 run_q <= '0;
        else if (run_q != RUN_W'(LOW_CYCLES)) run_q <= run_q + 1'b1;
      end

      assert_level_qualify_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i[g] && lvl && run_q != RUN_W'(LOW_CYCLES)) |=> !flag_o[g]);

      assert_level_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i[g] && lvl && pin_s[g] && $past(pin_s[g])) |=> !flag_o[g]);
    end
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(
  .NUM_PINS(NUM_PINS), .NUM_FULL(NUM_FULL), .LOW_CYCLES(LOW_CYCLES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sense_full_i(sense_full_i),
  .clr_i(clr_i), .pin_s(pin_s), .pin_q(pin_q), .flag_o(flag_o)
);

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  localparam int LOWC = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] pin_i = 3'b111;
  logic [2:0] en_i = 3'b111;
  logic [3:0] sense_full_i = 4'b1111;
  logic [0:0] sense_edge_i = 1'b1;
  logic [2:0] clr_i = 3'b000;
  logic [2:0] flag_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic [2:0] m_ff1 = 3'b111, m_s = 3'b111, m_prev = 3'b111, m_flag = 3'b000;
  int m_cnt [3] = '{0, 0, 0};

  always #10 clk_i = ~clk_i;

  ext_irq_sense i_ext_irq_sense (
    .clk_i, .rst_ni, .pin_i, .en_i, .sense_full_i, .sense_edge_i, .clr_i, .flag_o
  );

  function automatic logic [1:0] mode_of(int k);
    return (k < 2) ? sense_full_i[2*k +: 2] : {1'b1, sense_edge_i[0]};
  endfunction

  function automatic logic next_flag(int k);
    logic [1:0] m;
    logic r, f, hit;
    m   = mode_of(k);
    r   = m_s[k] & ~m_prev[k];
    f   = ~m_s[k] & m_prev[k];
    hit = (m == 2'b01) ? (r | f) : (m == 2'b10) ? f : (m == 2'b11) ? r : 1'b0;
    if (!en_i[k]) return 1'b0;
    if (m == 2'b00) return (m_cnt[k] == LOWC);
    return hit | (m_flag[k] & ~clr_i[k]);
  endfunction

  task automatic check(bit ok, string req, logic act, logic exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int c = 0; c < n; c++) begin
      logic [2:0] nf;
      @(posedge clk_i);
      for (int k = 0; k < 3; k++) nf[k] = next_flag(k);
      for (int k = 0; k < 3; k++)
        m_cnt[k] = m_s[k] ? 0 : (m_cnt[k] == LOWC ? LOWC : m_cnt[k] + 1);
      m_flag = nf;
      m_prev = m_s;
      m_s    = m_ff1;
      m_ff1  = pin_i;
      @(negedge clk_i);
      for (int k = 0; k < 3; k++)
        check(flag_o[k] === m_flag[k], (mode_of(k) == 2'b00) ? "R7 model" : "R3 model",
              flag_o[k], m_flag[k]);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk_i);
    check(flag_o === 3'b000, "R1", flag_o[0], 1'b0);
    rst_ni = 1'b1;
    tick(2);
    check(flag_o === 3'b000, "R1", flag_o[0], 1'b0);

    // R2 latency, R3 rise on pin0
    sense_full_i = 4'b11_11;
    pin_i[0] = 1'b0; tick(4);
    check(flag_o[0] == 1'b0, "R10 falling ignored in rise mode", flag_o[0], 1'b0);
    pin_i[0] = 1'b1; tick(2);
    check(flag_o[0] == 1'b0, "R2 not before edge k+2", flag_o[0], 1'b0);
    tick(1);
    check(flag_o[0] == 1'b1, "R2 set at edge k+2", flag_o[0], 1'b1);

    // R5 hold and per-pin clear
    tick(3);
    check(flag_o[0] == 1'b1, "R5 held", flag_o[0], 1'b1);
    clr_i = 3'b110; tick(1); clr_i = 3'b000;
    check(flag_o[0] == 1'b1, "R5 other clear ignored", flag_o[0], 1'b1);
    clr_i = 3'b001; tick(1); clr_i = 3'b000;
    check(flag_o[0] == 1'b0, "R5 own clear", flag_o[0], 1'b0);

    // R6 edge wins over clear (pin0 any edge)
    sense_full_i[1:0] = 2'b01;
    pin_i[0] = 1'b0; tick(3);
    check(flag_o[0] == 1'b1, "R3 any edge fall", flag_o[0], 1'b1);
    pin_i[0] = 1'b1; tick(2);
    clr_i[0] = 1'b1; tick(1); clr_i[0] = 1'b0;
    check(flag_o[0] == 1'b1, "R6 edge beats clear", flag_o[0], 1'b1);
    clr_i[0] = 1'b1; tick(1); clr_i[0] = 1'b0;
    check(flag_o[0] == 1'b0, "R6 later clear", flag_o[0], 1'b0);

    // R10 falling-only on pin1
    sense_full_i[3:2] = 2'b10;
    pin_i[1] = 1'b0; tick(3);
    check(flag_o[1] == 1'b1, "R3 pin1 falling", flag_o[1], 1'b1);
    clr_i[1] = 1'b1; tick(1); clr_i[1] = 1'b0;
    pin_i[1] = 1'b1; tick(4);
    check(flag_o[1] == 1'b0, "R10 rising ignored", flag_o[1], 1'b0);

    // R4 pin2
    sense_edge_i = 1'b1;
    pin_i[2] = 1'b0; tick(4);
    check(flag_o[2] == 1'b0, "R4 falling ignored when bit=1", flag_o[2], 1'b0);
    pin_i[2] = 1'b1; tick(3);
    check(flag_o[2] == 1'b1, "R4 rising when bit=1", flag_o[2], 1'b1);
    clr_i[2] = 1'b1; tick(1); clr_i[2] = 1'b0;
    sense_edge_i = 1'b0;
    pin_i[2] = 1'b0; tick(3);
    check(flag_o[2] == 1'b1, "R4 falling when bit=0", flag_o[2], 1'b1);
    clr_i[2] = 1'b1; tick(1); clr_i[2] = 1'b0;
    pin_i[2] = 1'b1; tick(4);
    check(flag_o[2] == 1'b0, "R4 rising ignored when bit=0", flag_o[2], 1'b0);

    // R7 level qualify on pin1
    sense_full_i[3:2] = 2'b00; tick(2);
    pin_i[1] = 1'b0; tick(4); pin_i[1] = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 8; c++) begin tick(1); seen |= flag_o[1]; end
    check(seen == 1'b0, "R7 four-cycle low ignored", seen, 1'b0);
    pin_i[1] = 1'b0; tick(7);
    check(flag_o[1] == 1'b0, "R7 not yet qualified", flag_o[1], 1'b0);
    tick(1);
    check(flag_o[1] == 1'b1, "R7 qualified after five", flag_o[1], 1'b1);
    clr_i[1] = 1'b1; tick(2); clr_i[1] = 1'b0;
    check(flag_o[1] == 1'b1, "R8 clear ignored in level", flag_o[1], 1'b1);
    pin_i[1] = 1'b1; tick(4);
    check(flag_o[1] == 1'b0, "R8 released", flag_o[1], 1'b0);

    // R9 disable
    sense_full_i[1:0] = 2'b01;
    pin_i[0] = 1'b0; tick(3);
    check(flag_o[0] == 1'b1, "R9 setup", flag_o[0], 1'b1);
    en_i[0] = 1'b0; tick(1);
    check(flag_o[0] == 1'b0, "R9 cleared on disable", flag_o[0], 1'b0);
    seen = 1'b0;
    for (int c = 0; c < 6; c++) begin
      pin_i[0] = ~pin_i[0]; tick(1); seen |= flag_o[0];
    end
    tick(4); seen |= flag_o[0];
    check(seen == 1'b0, "R9 no flag while disabled", seen, 1'b0);
    en_i[0] = 1'b1; tick(2);
    check(flag_o[0] == 1'b0, "R9 re-enable quiet", flag_o[0], 1'b0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int k = 0; k < 3; k++) if ($urandom_range(5) == 0) pin_i[k] = ~pin_i[k];
      if ($urandom_range(3) == 0) begin
        for (int k = 0; k < 3; k++) pin_i[k] = 1'b0;
        if ($urandom_range(1) == 0) pin_i = 3'b111;
      end
      clr_i = 3'($urandom_range(7)) & {3{$urandom_range(3) == 0}};
      if ($urandom_range(63) == 0) sense_full_i = 4'($urandom_range(15));
      if ($urandom_range(63) == 0) sense_edge_i = 1'($urandom_range(1));
      if ($urandom_range(127) == 0) en_i = 3'($urandom_range(7));
      if ($urandom_range(255) == 0) en_i = 3'b111;
      tick(1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule